// File: doc/BRIEF.md
# Frame-Counted Video Timing Generator

This block paces a digital TV pixel path. It produces horizontal sync, vertical sync, a data-enable strobe and the outgoing pixel word. It is set up through a plain register write port. The horizontal position is a pixel counter that runs within one line. The vertical position is a second counter that runs across the whole frame in pixel clocks, not in lines. Because of this, the vertical sync pulse and the vertical display window can start or end on any pixel of a line. Both counters start at zero on the first clock of the vertical sync pulse.

Inside the display window the pixel output comes from one of three sources. It is the incoming pixel when the source marks it valid. It is a programmable border colour when no valid pixel is present. After the source has reported an underflow, it is a programmable fill colour. Outside the window the pixel output is zero. Turning the generator on or off takes effect only on a frame boundary. A sticky interrupt flag marks every frame start and every completed stop, and a register write clears it.

Top module: `vtg_top`

## Requirements
- R1: After reset, and whenever the generator is stopped, both counters are zero, data-enable is low, the pixel output is zero, and each sync output sits at its inactive level.
- R2: While running, the line counter counts from 0 up to line period minus one and then wraps. It also returns to 0 at every frame wrap. The hsync pulse is active while the line counter is below the hsync width. Register 0x1 holds the line period in bits [11:0] and the hsync width in bits [27:16].
- R3: While running, the frame counter counts from 0 up to frame period minus one and then wraps. The vsync pulse is active while the frame counter is below the vsync width, so it can end in the middle of a line. Register 0x2 holds the frame period and register 0x3 holds the vsync width, both in bits [23:0].
- R4: Data-enable is high exactly when the line counter lies in the inclusive column range [first, last] and the frame counter lies in the inclusive range [vfirst + skew, vlast + skew]. Register 0x4 holds first in bits [11:0] and last in bits [27:16]. Register 0x5 holds vfirst and register 0x6 holds vlast, both in bits [23:0]. Register 0x7 holds skew in bits [11:0].
- R5: In register 0x8, bit 0 makes hsync active low and bit 1 makes vsync active low. Data-enable is always active high.
- R6: Inside the window, with no underflow, the pixel output is the input pixel when the valid input is high and the border colour (register 0x9, bits [23:0]) when it is low. Outside the window the pixel output is zero.
- R7: An underflow seen inside the window makes the pixel output show the fill colour (register 0xA, bits [23:0]) in window pixels from that cycle onward. If the recovery bit (register 0xA, bit 31) is set, normal pixel selection resumes with the next frame. If it is clear, the fill colour stays until the generator stops.
- R8: Bit 0 of register 0x0 is the enable request. When the generator is stopped and the request is set, the first frame starts one clock after the request register holds 1, with both counters at zero.
- R9: If the request is clear while the generator is running, it stops only after the last clock of the current frame. Clearing the request and setting it again within the same frame does not interrupt the frame sequence.
- R10: The irq output is set on the clock after each frame start (counters both zero while running) and on the clock after a stop. Writing 1 to bit 0 of register 0xB clears it. A set wins over a clear in the same cycle.
- R11: A write to an address other than 0x0 to 0xB changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Incoming pixel is valid this clock |
| pix_underflow | input | 1 | Pixel source ran dry this clock |
| pix_in | input | 24 | Incoming pixel |
| hsync | output | 1 | Horizontal sync, polarity per register 0x8 |
| vsync | output | 1 | Vertical sync, polarity per register 0x8 |
| de | output | 1 | Data enable, active high |
| pix_out | output | 24 | Outgoing pixel |
| irq | output | 1 | Sticky frame/stop interrupt flag |

## Verification
The bench programs a vsync width of one and a half lines. A design that counts vertical timing in lines would then end the pulse on a line boundary, or move the window by a whole line. The skew term would also be missed in either window bound, which shows as a one-pixel error at the vertical window edges. Disables are issued in mid-frame, including one that is cancelled before the frame ends. A design that applies enable changes at once would cut a frame short or restart it, and this shows as a jump in sync or irq timing. Underflow is tested once with recovery set and once with it clear. A fill that is dropped too early, or held into the next frame when recovery is set, shows up in the pixel word. Writes to unused addresses check that the decode has no aliases.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int HI_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'h0,
    A_LINE   = 4'h1,
    A_FRAME  = 4'h2,
    A_VWIDTH = 4'h3,
    A_HWIN   = 4'h4,
    A_VFIRST = 4'h5,
    A_VLAST  = 4'h6,
    A_SKEW   = 4'h7,
    A_POL    = 4'h8,
    A_BORDER = 4'h9,
    A_FILL   = 4'hA,
    A_IRQCLR = 4'hB
  } vtg_addr_e;

  // true on the last count of a period of length per
  function automatic logic f_last(input logic [31:0] cnt, input logic [31:0] per);
    return (cnt + 32'd1) >= per;
  endfunction

  // inclusive range test
  function automatic logic f_between(input logic [31:0] x, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (x >= lo) && (x <= hi);
  endfunction
endpackage

// File: rtl/vtg_regs.sv
`timescale 1ns/1ps
module vtg_regs import vtg_pkg::*; #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_req,
  output logic [HW-1:0]     hper,
  output logic [HW-1:0]     hsw,
  output logic [HW-1:0]     hfirst,
  output logic [HW-1:0]     hlast,
  output logic [FW-1:0]     fper,
  output logic [FW-1:0]     vsw,
  output logic [FW-1:0]     vfirst,
  output logic [FW-1:0]     vlast,
  output logic [HW-1:0]     skew,
  output logic              pol_h,
  output logic              pol_v,
  output logic [CW-1:0]     border,
  output logic [CW-1:0]     fill,
  output logic              recover,
  output logic              irq_clr
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  assign irq_clr = wr_en && (wr_addr == A_IRQCLR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req <= 1'b0; hper <= '0; hsw <= '0; hfirst <= '0; hlast <= '0;
      fper <= '0; vsw <= '0; vfirst <= '0; vlast <= '0; skew <= '0;
      pol_h <= 1'b0; pol_v <= 1'b0; border <= '0; fill <= '0; recover <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   en_req <= wr_data[0];
        A_LINE:   begin hper <= wr_data[HW-1:0]; hsw <= wr_data[HI_LSB+HW-1:HI_LSB]; end
        A_FRAME:  fper <= wr_data[FW-1:0];
        A_VWIDTH: vsw <= wr_data[FW-1:0];
        A_HWIN:   begin hfirst <= wr_data[HW-1:0]; hlast <= wr_data[HI_LSB+HW-1:HI_LSB]; end
        A_VFIRST: vfirst <= wr_data[FW-1:0];
        A_VLAST:  vlast <= wr_data[FW-1:0];
        A_SKEW:   skew <= wr_data[HW-1:0];
        A_POL:    begin pol_h <= wr_data[0]; pol_v <= wr_data[1]; end
        A_BORDER: border <= wr_data[CW-1:0];
        A_FILL:   begin fill <= wr_data[CW-1:0]; recover <= wr_data[DATA_W-1]; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vtg_counters.sv
`timescale 1ns/1ps
module vtg_counters import vtg_pkg::*; #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req,
  input  logic [HW-1:0] hper,
  input  logic [FW-1:0] fper,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          line_last,
  output logic          frame_last,
  output logic          stop_evt,
  output logic          frame_start
);
  assign line_last   = run && f_last(32'(hcnt), 32'(hper));
  assign frame_last  = run && f_last(32'(fcnt), 32'(fper));
  assign stop_evt    = frame_last && !en_req;
  assign frame_start = run && (hcnt == '0) && (fcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; hcnt <= '0; fcnt <= '0;
    end else if (!run) begin
      run <= en_req; hcnt <= '0; fcnt <= '0;
    end else if (stop_evt) begin
      run <= 1'b0; hcnt <= '0; fcnt <= '0;
    end else begin
      hcnt <= (line_last || frame_last) ? '0 : hcnt + HW'(1);
      fcnt <= frame_last ? '0 : fcnt + FW'(1);
    end
  end
endmodule

// File: rtl/vtg_pixel.sv
`timescale 1ns/1ps
module vtg_pixel import vtg_pkg::*; #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic          frame_last,
  input  logic          stop_evt,
  input  logic [HW-1:0] hsw,
  input  logic [FW-1:0] vsw,
  input  logic [HW-1:0] hfirst,
  input  logic [HW-1:0] hlast,
  input  logic [FW-1:0] vfirst,
  input  logic [FW-1:0] vlast,
  input  logic [HW-1:0] skew,
  input  logic          pol_h,
  input  logic          pol_v,
  input  logic [CW-1:0] border,
  input  logic [CW-1:0] fill,
  input  logic          recover,
  input  logic          pix_valid,
  input  logic          pix_underflow,
  input  logic [CW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_out,
  output logic          uf_hold
);
  logic hs_act, vs_act, in_cols, in_rows, uf_now;

  assign hs_act  = run && (32'(hcnt) < 32'(hsw));
  assign vs_act  = run && (32'(fcnt) < 32'(vsw));
  assign in_cols = f_between(32'(hcnt), 32'(hfirst), 32'(hlast));
  assign in_rows = f_between(32'(fcnt), 32'(vfirst) + 32'(skew), 32'(vlast) + 32'(skew));
  assign de      = run && in_cols && in_rows;
  assign uf_now  = de && pix_underflow;
  assign hsync   = hs_act ^ pol_h;
  assign vsync   = vs_act ^ pol_v;

  always_comb begin
    if (!de)                    pix_out = '0;
    else if (uf_hold || uf_now) pix_out = fill;
    else if (pix_valid)         pix_out = pix_in;
    else                        pix_out = border;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        uf_hold <= 1'b0;
    else if (!run || stop_evt || (frame_last && recover)) uf_hold <= 1'b0;
    else if (uf_now)                                   uf_hold <= 1'b1;
  end
endmodule

// File: rtl/vtg_top.sv
`timescale 1ns/1ps
module vtg_top import vtg_pkg::*; #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pix_valid,
  input  logic              pix_underflow,
  input  logic [CW-1:0]     pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CW-1:0]     pix_out,
  output logic              irq
);
  logic          en_req, pol_h, pol_v, recover, irq_clr;
  logic [HW-1:0] hper, hsw, hfirst, hlast, skew, hcnt;
  logic [FW-1:0] fper, vsw, vfirst, vlast, fcnt;
  logic [CW-1:0] border, fill;
  logic          run, line_last, frame_last, stop_evt, frame_start, uf_hold;

  vtg_regs #(.HW(HW), .FW(FW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_req(en_req), .hper(hper), .hsw(hsw), .hfirst(hfirst), .hlast(hlast),
    .fper(fper), .vsw(vsw), .vfirst(vfirst), .vlast(vlast), .skew(skew),
    .pol_h(pol_h), .pol_v(pol_v), .border(border), .fill(fill), .recover(recover),
    .irq_clr(irq_clr));

  vtg_counters #(.HW(HW), .FW(FW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .hper(hper), .fper(fper),
    .run(run), .hcnt(hcnt), .fcnt(fcnt), .line_last(line_last),
    .frame_last(frame_last), .stop_evt(stop_evt), .frame_start(frame_start));

  vtg_pixel #(.HW(HW), .FW(FW), .CW(CW)) u_pix (
    .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .frame_last(frame_last), .stop_evt(stop_evt), .hsw(hsw), .vsw(vsw),
    .hfirst(hfirst), .hlast(hlast), .vfirst(vfirst), .vlast(vlast), .skew(skew),
    .pol_h(pol_h), .pol_v(pol_v), .border(border), .fill(fill), .recover(recover),
    .pix_valid(pix_valid), .pix_underflow(pix_underflow), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .uf_hold(uf_hold));

  // sticky event flag: set has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       irq <= 1'b0;
    else if (frame_start || stop_evt) irq <= 1'b1;
    else if (irq_clr)                 irq <= 1'b0;
  end
endmodule

// File: rtl/vtg_checks.sv
`timescale 1ns/1ps
module vtg_checks #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [HW-1:0] hcnt,
  input logic [FW-1:0] fcnt,
  input logic          line_last,
  input logic          frame_last,
  input logic          frame_start,
  input logic          pol_h,
  input logic          pol_v,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          irq
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hcnt == '0 && fcnt == '0 && !de));

  p_idle_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == pol_h && vsync == pol_v));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_last && !frame_last) |=> (hcnt == $past(hcnt) + HW'(1)));

  p_start_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (hcnt == '0 && fcnt == '0));

  p_stop_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(frame_last));

  p_irq_on_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> irq);
endmodule

bind vtg_top vtg_checks #(.HW(HW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fcnt(fcnt),
  .line_last(line_last), .frame_last(frame_last), .frame_start(frame_start),
  .pol_h(pol_h), .pol_v(pol_v), .hsync(hsync), .vsync(vsync), .de(de), .irq(irq));

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_underflow = 1'b0;
  logic [23:0] pix_in = '0;
  logic        hsync, vsync, de, irq;
  logic [23:0] pix_out;

  always #5 clk = ~clk;

  vtg_top u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_valid(pix_valid), .pix_underflow(pix_underflow),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .irq(irq));

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference state
  int m_en, m_hper, m_hsw, m_hf, m_hl, m_fper, m_vsw, m_vf, m_vl, m_skew;
  int m_polh, m_polv, m_border, m_fill, m_rec;
  int m_run, m_h, m_f, m_uf, m_irq;

  function automatic int m_de();
    return (m_run != 0 && m_h >= m_hf && m_h <= m_hl &&
            m_f >= m_vf + m_skew && m_f <= m_vl + m_skew) ? 1 : 0;
  endfunction

  function automatic int m_pix();
    if (m_de() == 0) return 0;
    if (m_uf != 0 || pix_underflow) return m_fill;
    if (pix_valid) return int'(pix_in);
    return m_border;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_hper = 0; m_hsw = 0; m_hf = 0; m_hl = 0; m_fper = 0; m_vsw = 0;
      m_vf = 0; m_vl = 0; m_skew = 0; m_polh = 0; m_polv = 0; m_border = 0;
      m_fill = 0; m_rec = 0; m_run = 0; m_h = 0; m_f = 0; m_uf = 0; m_irq = 0;
    end else begin
      int fl, hl, stp, fs, dnow, nrun, nh, nf, nuf, nirq;
      fl   = (m_run != 0 && m_f + 1 >= m_fper) ? 1 : 0;
      hl   = (m_run != 0 && m_h + 1 >= m_hper) ? 1 : 0;
      stp  = (fl != 0 && m_en == 0) ? 1 : 0;
      fs   = (m_run != 0 && m_h == 0 && m_f == 0) ? 1 : 0;
      dnow = m_de();
      if (m_run == 0) begin nrun = m_en; nh = 0; nf = 0; end
      else if (stp != 0) begin nrun = 0; nh = 0; nf = 0; end
      else begin
        nrun = 1;
        nh = (hl != 0 || fl != 0) ? 0 : m_h + 1;
        nf = (fl != 0) ? 0 : m_f + 1;
      end
      if (m_run == 0 || stp != 0 || (fl != 0 && m_rec != 0)) nuf = 0;
      else if (dnow != 0 && pix_underflow) nuf = 1;
      else nuf = m_uf;
      if (fs != 0 || stp != 0) nirq = 1;
      else if (wr_en && wr_addr == 4'hB && wr_data[0]) nirq = 0;
      else nirq = m_irq;
      if (wr_en) begin
        case (wr_addr)
          4'h0: m_en = int'(wr_data[0]);
          4'h1: begin m_hper = int'(wr_data[11:0]); m_hsw = int'(wr_data[27:16]); end
          4'h2: m_fper = int'(wr_data[23:0]);
          4'h3: m_vsw = int'(wr_data[23:0]);
          4'h4: begin m_hf = int'(wr_data[11:0]); m_hl = int'(wr_data[27:16]); end
          4'h5: m_vf = int'(wr_data[23:0]);
          4'h6: m_vl = int'(wr_data[23:0]);
          4'h7: m_skew = int'(wr_data[11:0]);
          4'h8: begin m_polh = int'(wr_data[0]); m_polv = int'(wr_data[1]); end
          4'h9: m_border = int'(wr_data[23:0]);
          4'hA: begin m_fill = int'(wr_data[23:0]); m_rec = int'(wr_data[31]); end
          default: ;
        endcase
      end
      m_run = nrun; m_h = nh; m_f = nf; m_uf = nuf; m_irq = nirq;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [phase %s] at %0t got %0h exp %0h", req, phase, $time, got, exp);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int hs, vs;
      hs = ((m_run != 0 && m_h < m_hsw) ? 1 : 0) ^ m_polh;
      vs = ((m_run != 0 && m_f < m_vsw) ? 1 : 0) ^ m_polv;
      chk("R2 hsync", int'(hsync), hs);
      chk("R3 vsync", int'(vsync), vs);
      chk("R4 de", int'(de), m_de());
      chk("R6 pixel", int'(pix_out), m_pix());
      chk("R10 irq", int'(irq), m_irq);
    end
  end

  int cyc_n = 0;
  int vmode = 0;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cyc_n++;
      pix_in = 24'((cyc_n * 40503) ^ 24'h5A5A5A);
      case (vmode)
        0: pix_valid = 1'b1;
        1: pix_valid = (cyc_n % 3) != 0;
        default: pix_valid = 1'b0;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wr_data = '0;
  endtask

  // raise underflow for one clock inside the active window
  task automatic uf_in_window();
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #2;
      if (m_de() != 0) begin
        pix_underflow = 1'b1;
        @(posedge clk); #2;
        pix_underflow = 1'b0;
        break;
      end
    end
  endtask

  task automatic to_frame_mid(input int target);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #2;
      if (m_run != 0 && m_f == target) break;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R8 watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    phase = "R1";
    step(6);
    // directed reset-state check at the ports
    @(negedge clk);
    chk("R1 idle de", int'(de), 0);
    chk("R1 idle hsync", int'(hsync), 0);
    chk("R1 idle pixel", int'(pix_out), 0);

    phase = "R11";
    wr(4'h1, {4'h0, 12'd2, 4'h0, 12'd10});
    wr(4'h2, 32'd60);
    wr(4'h3, 32'd15);
    wr(4'h4, {4'h0, 12'd8, 4'h0, 12'd3});
    wr(4'h5, 32'd20);
    wr(4'h6, 32'd49);
    wr(4'h7, 32'd1);
    wr(4'h9, 32'h00_12_34);
    wr(4'hA, 32'h0000FF00);
    step(3);

    phase = "R8";
    wr(4'h0, 32'd1);
    step(130);

    phase = "R6";
    vmode = 1; step(70);
    vmode = 2; step(40);
    vmode = 0;

    phase = "R3";
    wr(4'h3, 32'd25);
    step(70);

    phase = "R5";
    wr(4'h8, 32'd3); step(65);
    wr(4'h8, 32'd1); step(65);
    wr(4'h8, 32'd0);

    phase = "R7";
    wr(4'hA, 32'h8000FF00);
    uf_in_window();
    step(130);
    wr(4'hA, 32'h0000F0F0);
    uf_in_window();
    step(140);

    phase = "R9";
    to_frame_mid(30);
    wr(4'h0, 32'd0);
    step(60);
    wr(4'h0, 32'd1);
    step(70);
    to_frame_mid(10);
    wr(4'h0, 32'd0);
    step(5);
    wr(4'h0, 32'd1);
    step(80);

    phase = "R10";
    wr(4'hB, 32'd1);
    step(20);
    wr(4'hB, 32'd0);
    step(70);
    wr(4'hB, 32'd1);
    step(50);

    phase = "R11";
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'hF, 32'h0000_0000);
    wr(4'hD, 32'h0000_0003);
    step(70);

    phase = "R9";
    wr(4'h0, 32'd0);
    step(80);
    @(negedge clk);
    chk("R9 stopped de", int'(de), 0);
    chk("R9 stopped vsync", int'(vsync), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule